// File: doc/BRIEF.md
# Wiper Position Recall and Store Sequencer

This block owns the tap position of a digitally controlled resistor ladder. It holds a volatile wiper register that drives the tap decoder, and a backing register that stands in for the nonvolatile cell holding the remembered position. Coming out of reset, the wiper sits at mid-scale. It moves to the remembered position only once a supply-good indication rises.

The serial bus front end hands the block decoded write strobes. Each strobe targets either the wiper alone or the backing register. A backing write loads both registers with the same 7-bit code and arms a store cycle. The STOP condition that closes that bus transaction starts a busy window of a programmable number of clock cycles, which models the cell programming time. While this window is open, the block refuses writes, STOP pulses and recall requests. The front end uses the busy output to stop acknowledging its address.

Either register can be read back over a combinational read port. A read never moves the wiper.

Top module: `tapmem_top`

## Requirements
- R1: While `rstN` is low and after its release, the wiper is 64 (binary 1000000), the backing register holds the parameter `STORE_INIT`, and `busy` is 0.
- R2: When `supplyOk` is seen high at a clock edge after being low at the previous edge (or at the first edge after reset), and `busy` is 0, the wiper takes the backing register's value at that edge.
- R3: A write with `wrEn`=1 and `wrSel`=1 loads `wrData[6:0]` into both the wiper and the backing register at that clock edge.
- R4: A write with `wrEn`=1 and `wrSel`=0 loads `wrData[6:0]` into the wiper only. The backing register is unchanged.
- R5: Bit 7 of `wrData` has no effect on either register.
- R6: A `stopSeen` pulse that follows a backing write raises `busy` at the next edge. `busy` then stays high for exactly `STORE_CYCLES` cycles. A `stopSeen` pulse with no pending backing write leaves `busy` low.
- R7: While `busy` is 1, write strobes, `stopSeen` pulses and supply-good rises are ignored. Both registers keep their values.
- R8: `rdData` is combinational. `rdSel`=0 returns {0, wiper} and `rdSel`=1 returns {0, backing register}. Reading has no effect on the wiper.
- R9: When a bus write and a recall occur at the same edge, the bus write determines the wiper value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| supplyOk | input | 1 | Supply-stable level; a rise requests a recall |
| wrEn | input | 1 | Single-cycle register write strobe from the bus front end |
| wrSel | input | 1 | Write target: 0 wiper only, 1 backing register and wiper |
| wrData | input | 8 | Write data; bit 7 ignored |
| stopSeen | input | 1 | Single-cycle pulse at a bus STOP condition |
| rdSel | input | 1 | Read target: 0 wiper, 1 backing register |
| rdData | output | 8 | Read value, bit 7 always 0 |
| wiper | output | 7 | Current tap position to the decoder |
| busy | output | 1 | Store cycle in progress; bus front end must stay off the bus |

## Verification
The assertions assume that `wrEn` and `stopSeen` are one-cycle strobes from a front end that never issues a write and a STOP for the same transaction at the same edge. They also assume that `supplyOk` is a level, so a recall comes only from its rise. The bench drives every input on the falling clock edge and holds each strobe for exactly one cycle. It pulses STOP only after the write strobe has dropped. It lowers and raises `supplyOk` over whole cycles, so each recall request is a single clean rise.

// File: rtl/tapmem_pkg.sv
package tapmem_pkg;
  // Strobes from control to datapath, all sampled at the same clock edge.
  typedef struct packed {
    logic wiperFromBus;   // load wiper from bus write data
    logic storeFromBus;   // load backing register from bus write data
    logic wiperFromStore; // recall: load wiper from backing register
  } tapStrobe_t;
endpackage

// File: rtl/tapmem_ctrl.sv
module tapmem_ctrl
  import tapmem_pkg::*;
#(
  parameter int STORE_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic       stopSeen,
  output tapStrobe_t strb,
  output logic       busy
);
  localparam int CW = $clog2(STORE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(STORE_CYCLES - 1);

  logic          prevOk;
  logic          armed;
  logic          busyQ;
  logic [CW-1:0] cnt;
  logic          okRise;
  logic          accept;
  logic          startStore;

  assign okRise     = supplyOk & ~prevOk;
  assign accept     = wrEn & ~busyQ;
  assign startStore = stopSeen & armed & ~busyQ;

  always_comb begin
    strb.wiperFromBus   = accept;
    strb.storeFromBus   = accept & wrSel;
    // bus write outranks a recall arriving at the same edge
    strb.wiperFromStore = okRise & ~busyQ & ~accept;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevOk <= 1'b0;
    end else begin
      prevOk <= supplyOk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (startStore) begin
      armed <= 1'b0;
    end else if (accept && wrSel) begin
      armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cnt   <= '0;
    end else if (busyQ) begin
      if (cnt == '0) begin
        busyQ <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (startStore) begin
      busyQ <= 1'b1;
      cnt   <= LOAD_VAL;
    end
  end

  assign busy = busyQ;

  // R6: a store window opens with the full count loaded
  a_r6_load_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> (cnt == LOAD_VAL));

  // R6: busy cannot end while count remains
  a_r6_hold_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && cnt != '0) |=> busyQ);

  // R6: busy never rises without a STOP
  a_r6_needs_stop: assert property (@(posedge clk) disable iff (!rstN)
    (!busyQ && !stopSeen) |=> !busyQ);

  // R7: no strobe leaves control during a store window
  a_r7_quiet_strobes: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (strb == '0));
endmodule

// File: rtl/tapmem_dp.sv
module tapmem_dp
  import tapmem_pkg::*;
#(
  parameter int TAP_BITS = 7,
  parameter logic [TAP_BITS-1:0] STORE_INIT = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  tapStrobe_t          strb,
  input  logic [TAP_BITS-1:0] wrData,
  input  logic                rdSel,
  output logic [TAP_BITS-1:0] wiper,
  output logic [TAP_BITS-1:0] stored,
  output logic [TAP_BITS:0]   rdData
);
  localparam logic [TAP_BITS-1:0] MID_CODE = TAP_BITS'(1) << (TAP_BITS - 1);

  logic [TAP_BITS-1:0] wiperQ;
  logic [TAP_BITS-1:0] storedQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wiperQ <= MID_CODE;
    end else if (strb.wiperFromBus) begin
      wiperQ <= wrData;
    end else if (strb.wiperFromStore) begin
      wiperQ <= storedQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      storedQ <= STORE_INIT;
    end else if (strb.storeFromBus) begin
      storedQ <= wrData;
    end
  end

  always_comb begin
    if (rdSel) rdData = {1'b0, storedQ};
    else       rdData = {1'b0, wiperQ};
  end

  assign wiper  = wiperQ;
  assign stored = storedQ;

  // R3: after a backing write both registers agree
  a_r3_both_match: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeFromBus |=> (wiperQ == storedQ));

  // R4: a wiper-only write leaves the backing register alone
  a_r4_store_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wiperFromBus && !strb.storeFromBus) |=> $stable(storedQ));

  // R2: recall copies the backing value
  a_r2_recall_copy: assert property (@(posedge clk) disable iff (!rstN)
    strb.wiperFromStore |=> (wiperQ == $past(storedQ)));
endmodule

// File: rtl/tapmem_top.sv
module tapmem_top
  import tapmem_pkg::*;
#(
  parameter int TAP_BITS = 7,
  parameter int STORE_CYCLES = 250000,
  parameter logic [TAP_BITS-1:0] STORE_INIT = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                supplyOk,
  input  logic                wrEn,
  input  logic                wrSel,
  input  logic [TAP_BITS:0]   wrData,
  input  logic                stopSeen,
  input  logic                rdSel,
  output logic [TAP_BITS:0]   rdData,
  output logic [TAP_BITS-1:0] wiper,
  output logic                busy
);
  tapStrobe_t          strb;
  logic [TAP_BITS-1:0] storedVal;

  tapmem_ctrl #(.STORE_CYCLES(STORE_CYCLES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .supplyOk (supplyOk),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .stopSeen (stopSeen),
    .strb     (strb),
    .busy     (busy)
  );

  tapmem_dp #(.TAP_BITS(TAP_BITS), .STORE_INIT(STORE_INIT)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData[TAP_BITS-1:0]),
    .rdSel  (rdSel),
    .wiper  (wiper),
    .stored (storedVal),
    .rdData (rdData)
  );

  // R7: a cycle spent busy leaves both registers where they were
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(wiper) && $stable(storedVal)));
endmodule

// File: tb/tapmem_top_test.sv
module tapmem_top_test;
  localparam int NCYC = 8;
  localparam logic [6:0] INIT = 7'd23;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       supplyOk = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrSel = 1'b0;
  logic [7:0] wrData = '0;
  logic       stopSeen = 1'b0;
  logic       rdSel = 1'b0;
  logic [7:0] rdData;
  logic [6:0] wiper;
  logic       busy;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tapmem_top #(.TAP_BITS(7), .STORE_CYCLES(NCYC), .STORE_INIT(INIT)) uut (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .stopSeen(stopSeen), .rdSel(rdSel), .rdData(rdData),
    .wiper(wiper), .busy(busy)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic readBack(logic sel, output logic [7:0] val);
    rdSel = sel;
    #1;
    val = rdData;
  endtask

  task automatic busWrite(logic sel, logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseStop();
    @(negedge clk);
    stopSeen = 1'b1;
    @(negedge clk);
    stopSeen = 1'b0;
  endtask

  task automatic supplyRise();
    @(negedge clk);
    supplyOk = 1'b0;
    @(negedge clk);
    supplyOk = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] v;
    @(negedge clk);
    check("R1 wiper mid", wiper, 64);
    check("R1 busy low", busy, 0);
    readBack(1'b1, v);
    check("R1 store init", v, INIT);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 wiper after release", wiper, 64);
  endtask

  task automatic testRecall();
    @(negedge clk);
    supplyOk = 1'b1;
    @(negedge clk);
    check("R2 recall", wiper, INIT);
  endtask

  task automatic testVolatile();
    logic [7:0] v;
    busWrite(1'b0, 8'hFF);
    check("R5 msb ignored wiper", wiper, 127);
    readBack(1'b1, v);
    check("R4 store unchanged", v, INIT);
    readBack(1'b0, v);
    check("R8 read wiper", v, 127);
    busWrite(1'b0, 8'h11);
    check("R4 wiper low code", wiper, 17);
  endtask

  task automatic testReadNoDisturb();
    logic [7:0] v;
    for (int i = 0; i < 4; i++) begin
      readBack(i[0], v);
      @(negedge clk);
    end
    check("R8 read leaves wiper", wiper, 17);
  endtask

  task automatic testStoreCycle();
    logic [7:0] v;
    int n;
    busWrite(1'b1, 8'h85);
    check("R3 wiper loaded", wiper, 5);
    readBack(1'b1, v);
    check("R3 store loaded R5 msb", v, 5);
    check("R6 no busy before stop", busy, 0);
    pulseStop();
    check("R6 busy after stop", busy, 1);
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    check("R6 busy length", n, NCYC);
  endtask

  task automatic testBareStop();
    pulseStop();
    check("R6 bare stop", busy, 0);
    @(negedge clk);
    check("R6 bare stop later", busy, 0);
  endtask

  task automatic testBusyBlocks();
    logic [7:0] v;
    busWrite(1'b1, 8'h30);
    pulseStop();
    busWrite(1'b0, 8'h40);
    check("R7 wiper write blocked", wiper, 48);
    busWrite(1'b1, 8'h41);
    readBack(1'b1, v);
    check("R7 store write blocked", v, 48);
    pulseStop();
    waitIdle();
    check("R7 idle after window", busy, 0);
    pulseStop();
    check("R7 stop during busy not armed", busy, 0);
  endtask

  task automatic testRecallAfterWrite();
    busWrite(1'b0, 8'h7A);
    check("R4 wiper moved", wiper, 122);
    supplyRise();
    check("R2 second recall", wiper, 48);
  endtask

  task automatic testWriteBeatsRecall();
    @(negedge clk);
    supplyOk = 1'b0;
    @(negedge clk);
    supplyOk = 1'b1;
    wrEn = 1'b1; wrSel = 1'b0; wrData = 8'h09;
    @(negedge clk);
    wrEn = 1'b0;
    check("R9 write wins", wiper, 9);
  endtask

  initial begin
    testReset();
    testRecall();
    testVolatile();
    testReadNoDisturb();
    testStoreCycle();
    testBareStop();
    testBusyBlocks();
    testRecallAfterWrite();
    testWriteBeatsRecall();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule